// File: doc/BRIEF.md
# Sample Output Demultiplexer and Forwarded Clock Generator

This block sits between one converter channel and its output pins. It takes one 12-bit sample and one out-of-range flag per sample period. In half-rate mode it pairs each earlier sample with the sample that follows it and presents the two together on two buses. In full-rate mode it passes every sample to a single bus and floats the second bus. It also produces the forwarded data clock, whose rate and edge placement depend on the mode, and a free-running reference clock at a quarter of the sample rate. A test-pattern mode replaces live samples with a fixed four-word cycle.

The block runs on one internal clock `clk` at twice the sample rate. The sample clock is modelled as a clock enable that is active on every second `clk` edge. Because the internal clock is twice the sample rate, the data clock can be placed half-way through a data-valid window. Electrical output behaviour is not modelled.

Top module: `smp_demux_clkout`

## Requirements
- R1: While `rst_n` is low, both data buses, both flags, `dclk` and `refclk` are 0. This assumes `ndm_sel` is low.
- R2: A sample is taken from the inputs on every second rising edge of `clk`. The first is taken at the second edge after reset release, and the rest follow on every even-numbered edge.
- R3: With `ndm_sel` low, odd-numbered samples (counted from 1 after reset, in every mode) are held internally. Each even-numbered sample appears on `dout_late` at the edge that takes it. At the same edge, the held sample before it appears on `dout_early`. Both buses then stay stable until the next pair.
- R4: With `ndm_sel` high, `dout_late` takes every sample at the edge that takes it. `dout_early` and `oor_early` are high-impedance for as long as `ndm_sel` is high.
- R5: Each out-of-range flag travels with its own sample. `oor_late` goes with `dout_late` and `oor_early` goes with `dout_early`.
- R6: With `ndm_sel` low and `ddr90_sel` low, `dclk` toggles exactly at the edges where the pair is updated. This gives a period of 8 `clk` cycles.
- R7: With `ndm_sel` low and `ddr90_sel` high, `dclk` toggles at the edges that take odd-numbered samples. These edges fall 2 `clk` cycles after each pair update, in the middle of the valid window.
- R8: With `ndm_sel` high, `dclk` toggles at every sample edge, giving a period of 4 `clk` cycles. `ddr90_sel` has no effect in this mode.
- R9: `refclk` equals 1 exactly when the number of `clk` edges since reset release, taken modulo 8, is 4 to 7. Its period is 8 `clk` cycles.
- R10: With `tpat_en` high, each sample slot carries the next word of the cycle 0x000, 0xFFF, 0xAAA, 0x555, and its flag is 0. A slot taken while `tpat_en` is low resets the cycle, so the next enabled slot carries 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| smp_data | input | 12 | Converter sample |
| smp_oor | input | 1 | Out-of-range flag for `smp_data` |
| ndm_sel | input | 1 | 1: full-rate single bus, 0: half-rate paired buses |
| ddr90_sel | input | 1 | 1: data clock edge mid-window (half-rate mode only) |
| tpat_en | input | 1 | Replace samples with the test pattern |
| dout_late | output | 12 | Later sample of a pair, or every sample at full rate |
| oor_late | output | 1 | Flag for `dout_late` |
| dout_early | output | 12 | Earlier sample of a pair; high-impedance at full rate |
| oor_early | output | 1 | Flag for `dout_early`; high-impedance at full rate |
| dclk | output | 1 | Forwarded data clock |
| refclk | output | 1 | Reference clock at one quarter of the sample rate |

## Verification
The embedded assertions check the following on every cycle:
- the sample enable alternates;
- the paired buses stay still between pair updates;
- in full-rate mode the main bus takes the sampled input;
- the data clock moves only on sample edges;
- the reference clock rises only at its fixed count;
- the test-pattern cycle is rewound whenever a slot is taken with the pattern off.

Some behaviour only the bench's scenarios can show. These are the exact pairing order from reset, the choice between 0° and 90° data-clock placement, the high-impedance bus, flags following their samples across mode changes, and the exact pattern words after re-entry. The bench shows these by comparing all outputs every cycle against a behavioural model.

// File: rtl/smp_demux_pkg.sv
package smp_demux_pkg;

  // Position within the four-word test cycle.
  typedef enum logic [1:0] {
    TP_ZERO   = 2'd0,
    TP_ONES   = 2'd1,
    TP_ODD_HI = 2'd2,
    TP_EVN_HI = 2'd3
  } tp_step_e;

  localparam int unsigned CNT_W = 3;   // clk edges per reference-clock period = 2**CNT_W

endpackage

// File: rtl/sdc_timebase.sv
module sdc_timebase
  import smp_demux_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output logic tick,
  output logic refclk
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Sample enable on every second clk edge.
  assign tick   = cnt_q[0];
  assign refclk = cnt_q[CNT_W-1];

  a_r2_tick_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  a_r9_ref_rise_point: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refclk) |-> $past(cnt_q) == 3'd3);

endmodule

// File: rtl/sdc_pattern.sv
module sdc_pattern
  import smp_demux_pkg::*;
#(
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  output logic [DW-1:0] pat
);

  tp_step_e step_q;
  tp_step_e step_d;

  always_comb begin
    step_d = step_q;
    if (tick) begin
      if (en) step_d = tp_step_e'(step_q + 2'd1);
      else    step_d = TP_ZERO;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= TP_ZERO;
    else        step_q <= step_d;
  end

  for (genvar b = 0; b < DW; b++) begin : g_bit
    localparam logic ODD_POS = ((b % 2) == 1);
    always_comb begin
      unique case (step_q)
        TP_ZERO:   pat[b] = 1'b0;
        TP_ONES:   pat[b] = 1'b1;
        TP_ODD_HI: pat[b] = ODD_POS;
        default:   pat[b] = ~ODD_POS;
      endcase
    end
  end

  a_r10_cycle_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !en) |=> step_q == TP_ZERO);

endmodule

// File: rtl/sdc_pairer.sv
module sdc_pairer #(
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ndm,
  input  logic [DW-1:0] din,
  input  logic          din_oor,
  output logic [DW-1:0] late_q,
  output logic          late_oor_q,
  output logic [DW-1:0] early_q,
  output logic          early_oor_q,
  output logic          pair_ph
);

  logic [DW-1:0] hold_q, hold_d;
  logic          hold_oor_q, hold_oor_d;
  logic [DW-1:0] late_d, early_d;
  logic          late_oor_d, early_oor_d;
  logic          ph_q, ph_d;
  logic          late_en, early_en, hold_en;

  // Clock enables: hold on first of pair, publish on second (or every slot at full rate).
  always_comb begin
    hold_en  = tick && !ph_q;
    late_en  = tick && (ndm || ph_q);
    early_en = tick && !ndm && ph_q;
    ph_d     = tick ? ~ph_q : ph_q;
  end

  always_comb begin
    hold_d      = hold_en  ? din        : hold_q;
    hold_oor_d  = hold_en  ? din_oor    : hold_oor_q;
    late_d      = late_en  ? din        : late_q;
    late_oor_d  = late_en  ? din_oor    : late_oor_q;
    early_d     = early_en ? hold_q     : early_q;
    early_oor_d = early_en ? hold_oor_q : early_oor_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q      <= '0;
      hold_oor_q  <= 1'b0;
      late_q      <= '0;
      late_oor_q  <= 1'b0;
      early_q     <= '0;
      early_oor_q <= 1'b0;
      ph_q        <= 1'b0;
    end else begin
      hold_q      <= hold_d;
      hold_oor_q  <= hold_oor_d;
      late_q      <= late_d;
      late_oor_q  <= late_oor_d;
      early_q     <= early_d;
      early_oor_q <= early_oor_d;
      ph_q        <= ph_d;
    end
  end

  assign pair_ph = ph_q;

  a_r3_pair_stable_late: assert property (@(posedge clk) disable iff (!rst_n)
    (!ndm && !(tick && ph_q)) |=> $stable(late_q));

  a_r3_pair_stable_early: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && ph_q) |=> $stable(early_q));

  a_r4_full_rate_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ndm) |=> (late_q == $past(din)) && (late_oor_q == $past(din_oor)));

endmodule

// File: rtl/sdc_dclk.sv
module sdc_dclk (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ndm,
  input  logic ddr90,
  input  logic pair_ph,
  output logic dclk
);

  logic dclk_q, dclk_d;
  logic flip;

  // Full rate: every slot. Half rate: pair edge (0 deg) or mid-window slot (90 deg).
  always_comb begin
    flip   = tick && (ndm || (pair_ph ^ ddr90));
    dclk_d = flip ? ~dclk_q : dclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dclk_q <= 1'b0;
    else        dclk_q <= dclk_d;
  end

  assign dclk = dclk_q;

  a_r6_dclk_on_slots: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dclk_q) |-> $past(tick));

endmodule

// File: rtl/smp_demux_clkout.sv
module smp_demux_clkout #(
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] smp_data,
  input  logic          smp_oor,
  input  logic          ndm_sel,
  input  logic          ddr90_sel,
  input  logic          tpat_en,
  output logic [DW-1:0] dout_late,
  output logic          oor_late,
  output logic [DW-1:0] dout_early,
  output logic          oor_early,
  output logic          dclk,
  output logic          refclk
);

  logic          tick;
  logic          pair_ph;
  logic [DW-1:0] pat;
  logic [DW-1:0] sel_data;
  logic          sel_oor;
  logic [DW-1:0] early_q;
  logic          early_oor_q;

  sdc_timebase u_tb (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .refclk (refclk)
  );

  sdc_pattern #(.DW(DW)) u_pat (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .en    (tpat_en),
    .pat   (pat)
  );

  always_comb begin
    sel_data = tpat_en ? pat  : smp_data;
    sel_oor  = tpat_en ? 1'b0 : smp_oor;
  end

  sdc_pairer #(.DW(DW)) u_pair (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .ndm         (ndm_sel),
    .din         (sel_data),
    .din_oor     (sel_oor),
    .late_q      (dout_late),
    .late_oor_q  (oor_late),
    .early_q     (early_q),
    .early_oor_q (early_oor_q),
    .pair_ph     (pair_ph)
  );

  sdc_dclk u_dclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .ndm     (ndm_sel),
    .ddr90   (ddr90_sel),
    .pair_ph (pair_ph),
    .dclk    (dclk)
  );

  assign dout_early = ndm_sel ? {DW{1'bz}} : early_q;
  assign oor_early  = ndm_sel ? 1'bz       : early_oor_q;

  // Pairing phase flips exactly once per sample slot.
  a_r3_phase_per_slot: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> pair_ph != $past(pair_ph));

endmodule

// File: tb/smp_demux_clkout_tb_top.sv
module smp_demux_clkout_tb_top;

  localparam int DW = 12;

  logic          clk;
  logic          rst_n;
  logic [DW-1:0] smp_data;
  logic          smp_oor;
  logic          ndm_sel;
  logic          ddr90_sel;
  logic          tpat_en;
  logic [DW-1:0] dout_late;
  logic          oor_late;
  logic [DW-1:0] dout_early;
  logic          oor_early;
  logic          dclk;
  logic          refclk;

  int n_chk;
  int n_fail;

  smp_demux_clkout #(.DW(DW)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_data   (smp_data),
    .smp_oor    (smp_oor),
    .ndm_sel    (ndm_sel),
    .ddr90_sel  (ddr90_sel),
    .tpat_en    (tpat_en),
    .dout_late  (dout_late),
    .oor_late   (oor_late),
    .dout_early (dout_early),
    .oor_early  (oor_early),
    .dclk       (dclk),
    .refclk     (refclk)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Behavioural reference model.
  int            e_cnt;
  int            s_cnt;
  int            tp_k;
  logic [DW-1:0] m_late, m_early, m_hold;
  logic          m_loor, m_eoor, m_hoor;
  logic          m_dclk;
  logic          m_tp_slot;

  function automatic logic [DW-1:0] tp_word(int k);
    case (k % 4)
      0:       return 12'h000;
      1:       return 12'hFFF;
      2:       return 12'hAAA;
      default: return 12'h555;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      e_cnt = 0; s_cnt = 0; tp_k = 0;
      m_late = '0; m_early = '0; m_hold = '0;
      m_loor = 0; m_eoor = 0; m_hoor = 0; m_dclk = 0; m_tp_slot = 0;
    end else begin
      logic [DW-1:0] s;
      logic          so;
      e_cnt++;
      if (e_cnt % 2 == 0) begin  // R2: slot on even-numbered edges
        if (tpat_en) begin s = tp_word(tp_k); so = 1'b0; tp_k++; end
        else begin s = smp_data; so = smp_oor; tp_k = 0; end
        s_cnt++;
        if (ndm_sel) begin
          m_late = s; m_loor = so; m_dclk = ~m_dclk;
        end else if (s_cnt % 2 == 1) begin
          m_hold = s; m_hoor = so;
          if (ddr90_sel) m_dclk = ~m_dclk;
        end else begin
          m_early = m_hold; m_eoor = m_hoor; m_late = s; m_loor = so;
          if (!ddr90_sel) m_dclk = ~m_dclk;
        end
      end
    end
  end

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    string dtag;
    string ctag;
    dtag = tpat_en ? "R10" : (ndm_sel ? "R2,R4" : "R2,R3");
    ctag = ndm_sel ? "R8" : (ddr90_sel ? "R7" : "R6");
    chk(dtag, dout_late, m_late);
    chk("R5", {11'd0, oor_late}, {11'd0, m_loor});
    if (ndm_sel) begin
      chk("R4", dout_early, {DW{1'bz}});
      chk("R4", {11'd0, oor_early}, {11'd0, 1'bz});
    end else begin
      chk(dtag, dout_early, m_early);
      chk("R5", {11'd0, oor_early}, {11'd0, m_eoor});
    end
    chk(ctag, {11'd0, dclk}, {11'd0, m_dclk});
    chk("R9", {11'd0, refclk}, {11'd0, logic'((e_cnt % 8) >= 4)});
  endtask

  task automatic run(int cycles, logic ndm, logic d90, logic tp);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      compare_all();
      ndm_sel   = ndm;
      ddr90_sel = d90;
      tpat_en   = tp;
      smp_data  = DW'($urandom);
      smp_oor   = ($urandom % 4) == 0;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 0; smp_data = '0; smp_oor = 0;
    ndm_sel = 0; ddr90_sel = 0; tpat_en = 0;
    repeat (3) @(negedge clk);
    // R1: outputs cleared while reset is held
    chk("R1", dout_late, '0);
    chk("R1", dout_early, '0);
    chk("R1", {10'd0, oor_late, oor_early}, '0);
    chk("R1", {10'd0, dclk, refclk}, '0);
    rst_n = 1;
    run(40, 0, 0, 0);   // half rate, 0 deg
    run(40, 0, 1, 0);   // half rate, 90 deg
    run(40, 1, 0, 0);   // full rate
    run(20, 1, 1, 0);   // full rate, phase select ignored
    run(30, 0, 0, 1);   // pattern, half rate
    run(6,  0, 0, 0);   // leave pattern
    run(26, 0, 1, 1);   // re-enter: cycle restarts
    run(30, 1, 0, 1);   // pattern, full rate
    run(10, 0, 0, 0);
    @(negedge clk);
    compare_all();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule